// File: doc/BRIEF.md
# Wi-Fi/Bluetooth Coexistence Arbiter

This block sits on the WLAN side of a packet traffic arbitration link with a nearby Bluetooth radio. The Bluetooth device raises a request line when it wants the shared medium for a slot. In three-wire mode it also drives a priority line. The arbiter weighs that request against the current WLAN activity and a configured priority policy. It then drives an activity line back to the Bluetooth device: high refuses the slot and low grants it. When a slot is granted, the arbiter also raises a hold-off output that tells the local WLAN logic to stay off the air.

Every coexistence function can be placed on any of seven general-purpose pads through a per-pad function code. Pad inputs are resynchronised to the local clock before they are used. An antenna-switch function can be placed on a pad as well. It is driven straight from configuration and does not pass through the arbitration.

Top module: `coex_arbiter`

## Requirements
- R1: After reset, a pad assigned to the activity function drives 0 and `wl_holdoff_o` is 0.
- R2: Each pad input passes through a two-flop synchroniser. A request raised on a pad between clock edges is acted on at the third rising edge after it changes, and not at the second.
- R3: On an update with the block enabled, the activity line goes high (deny) when WLAN is active and either the effective priority is normal or `cfg_wl_wins_i` is 1.
- R4: On an update where the Bluetooth request is high and R3 does not deny, the activity line goes low (grant) and `wl_holdoff_o` goes high. The hold-off output is never high while the activity line is high.
- R5: With `cfg_three_wire_i` = 0 the priority pad is ignored and every request is treated as normal priority. With `cfg_three_wire_i` = 1, priority pad high means high priority.
- R6: The decision is updated only on a rising edge of the synchronised request or on a change of `wl_active_i`. A change of `wl_active_i` with no request pending also updates the activity line. Configuration changes between these events leave the outputs unchanged.
- R7: While a granted slot is in progress (`wl_holdoff_o` high), changes of `wl_active_i` leave the activity line unchanged. `wl_holdoff_o` clears one cycle after the synchronised request falls.
- R8: With `cfg_en_i` = 0, the activity line is forced low from the next edge and `wl_holdoff_o` is never asserted.
- R9: Pad function codes are 3 bits per pad, with pad i at bits [3i+2:3i]: 0 none, 1 request input, 2 priority input, 3 activity output, 4 antenna-switch output. If several pads carry the same input code, the lowest-indexed pad is used. An input function with no pad reads as 0.
- R10: A pad with code 3 always has its output enable set and carries the activity line. A pad with code 4 drives `cfg_ant_val_i`, and its output enable follows `cfg_ant_en_i`. All other pads have output and output enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Coexistence enable |
| cfg_three_wire_i | input | 1 | 1 selects three-wire mode (priority input used) |
| cfg_wl_wins_i | input | 1 | WLAN activity beats high-priority Bluetooth |
| cfg_ant_en_i | input | 1 | Output enable for antenna-switch pads |
| cfg_ant_val_i | input | 1 | Value driven on antenna-switch pads |
| cfg_pad_fn_i | input | NUM_PADS*3 | Function code per pad |
| wl_active_i | input | 1 | WLAN activity, synchronous to clk_i |
| pad_in_i | input | NUM_PADS | Pad input levels, asynchronous |
| pad_out_o | output | NUM_PADS | Pad output levels |
| pad_oe_o | output | NUM_PADS | Pad output enables |
| wl_holdoff_o | output | 1 | WLAN must hold off for a granted Bluetooth slot |

## Verification
A wrong decision register shows up on the activity pad one edge after a change of WLAN activity, or three edges after a request pad rises. The sweeps sample at exactly those edges, so a missing or extra synchroniser stage is caught as an off-by-one. A hold-off flag that stays set shows up as `wl_holdoff_o` still high four cycles after the request pad drops. A wrong pad decode shows up in the same cycle as a misplaced output enable or an ignored request.

// File: rtl/coex_pkg.sv
package coex_pkg;
  localparam int unsigned FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_NONE   = 3'd0,
    FN_BT_REQ = 3'd1,
    FN_BT_PRI = 3'd2,
    FN_WL_ACT = 3'd3,
    FN_ANT_SW = 3'd4
  } pad_fn_e;
endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/coex_pad_in_sel.sv
module coex_pad_in_sel
  import coex_pkg::*;
#(
  parameter int unsigned NUM_PADS = 7
) (
  input  logic [NUM_PADS*FN_W-1:0] cfg_pad_fn_i,
  input  logic [NUM_PADS-1:0]      pad_s_i,
  output logic                     req_o,
  output logic                     pri_o
);
  // scan from the top so the lowest matching pad is the last to write
  always_comb begin
    req_o = 1'b0;
    pri_o = 1'b0;
    for (int i = NUM_PADS - 1; i >= 0; i--) begin
      if (pad_fn_e'(cfg_pad_fn_i[i*FN_W +: FN_W]) == FN_BT_REQ) req_o = pad_s_i[i];
      if (pad_fn_e'(cfg_pad_fn_i[i*FN_W +: FN_W]) == FN_BT_PRI) pri_o = pad_s_i[i];
    end
  end
endmodule

// File: rtl/coex_decide.sv
module coex_decide (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic three_wire_i,
  input  logic wl_wins_i,
  input  logic wl_active_i,
  input  logic req_i,
  input  logic pri_i,
  output logic wl_act_o,
  output logic holdoff_o,
  output logic upd_o
);
  logic req_q, act_q, wl_act_q, hold_q;
  logic rise, fall, act_chg, pri_eff, deny;

  assign rise    = req_i & ~req_q;
  assign fall    = ~req_i & req_q;
  assign act_chg = wl_active_i ^ act_q;
  // activity changes are ignored while a granted slot runs
  assign upd_o   = rise | (act_chg & ~hold_q);
  assign pri_eff = three_wire_i & pri_i;
  assign deny    = wl_active_i & (~pri_eff | wl_wins_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      req_q <= req_i;
      act_q <= wl_active_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_act_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (!en_i) begin
      wl_act_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (upd_o) begin
      wl_act_q <= deny;
      hold_q   <= req_i & ~deny;
    end else if (fall) begin
      hold_q   <= 1'b0;
    end
  end

  assign wl_act_o  = wl_act_q;
  assign holdoff_o = hold_q;
endmodule

// File: rtl/coex_pad_out_drv.sv
module coex_pad_out_drv
  import coex_pkg::*;
#(
  parameter int unsigned NUM_PADS = 7
) (
  input  logic [NUM_PADS*FN_W-1:0] cfg_pad_fn_i,
  input  logic                     wl_act_i,
  input  logic                     ant_en_i,
  input  logic                     ant_val_i,
  output logic [NUM_PADS-1:0]      pad_out_o,
  output logic [NUM_PADS-1:0]      pad_oe_o
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    pad_fn_e fn;
    assign fn = pad_fn_e'(cfg_pad_fn_i[i*FN_W +: FN_W]);
    always_comb begin
      unique case (fn)
        FN_WL_ACT: begin pad_out_o[i] = wl_act_i;  pad_oe_o[i] = 1'b1;     end
        FN_ANT_SW: begin pad_out_o[i] = ant_val_i; pad_oe_o[i] = ant_en_i; end
        default:   begin pad_out_o[i] = 1'b0;      pad_oe_o[i] = 1'b0;     end
      endcase
    end
  end
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_en_i,
  input  logic                     cfg_three_wire_i,
  input  logic                     cfg_wl_wins_i,
  input  logic                     cfg_ant_en_i,
  input  logic                     cfg_ant_val_i,
  input  logic [NUM_PADS*FN_W-1:0] cfg_pad_fn_i,
  input  logic                     wl_active_i,
  input  logic [NUM_PADS-1:0]      pad_in_i,
  output logic [NUM_PADS-1:0]      pad_out_o,
  output logic [NUM_PADS-1:0]      pad_oe_o,
  output logic                     wl_holdoff_o
);
  logic [NUM_PADS-1:0] pad_s;
  logic req_s, pri_s, wl_act, upd;

  coex_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_s)
  );

  coex_pad_in_sel #(.NUM_PADS(NUM_PADS)) u_in_sel (
    .cfg_pad_fn_i(cfg_pad_fn_i),
    .pad_s_i     (pad_s),
    .req_o       (req_s),
    .pri_o       (pri_s)
  );

  coex_decide u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg_en_i),
    .three_wire_i(cfg_three_wire_i),
    .wl_wins_i   (cfg_wl_wins_i),
    .wl_active_i (wl_active_i),
    .req_i       (req_s),
    .pri_i       (pri_s),
    .wl_act_o    (wl_act),
    .holdoff_o   (wl_holdoff_o),
    .upd_o       (upd)
  );

  coex_pad_out_drv #(.NUM_PADS(NUM_PADS)) u_out_drv (
    .cfg_pad_fn_i(cfg_pad_fn_i),
    .wl_act_i    (wl_act),
    .ant_en_i    (cfg_ant_en_i),
    .ant_val_i   (cfg_ant_val_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o)
  );
endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_en_i,
  input logic wl_holdoff_o,
  input logic wl_act,
  input logic req_s,
  input logic upd
);
  p_dis_act_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> !wl_act);

  p_dis_no_holdoff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> !wl_holdoff_o);

  p_grant_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_holdoff_o |-> !wl_act);

  p_slot_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_holdoff_o |=> $stable(wl_act));

  p_holdoff_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_holdoff_o |-> (req_s || $past(req_s)));

  p_event_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !upd) |=> $stable(wl_act));
endmodule

bind coex_arbiter coex_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en_i    (cfg_en_i),
  .wl_holdoff_o(wl_holdoff_o),
  .wl_act      (wl_act),
  .req_s       (req_s),
  .upd         (upd)
);

// File: tb/sim_coex_arbiter.sv
`timescale 1ns/1ps
module sim_coex_arbiter;
  localparam int NP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, tw = 1'b0, wins = 1'b0, ant_en = 1'b0, ant_val = 1'b0;
  logic [NP*3-1:0] cfg = '0;
  logic wl_act_in = 1'b0;
  logic [NP-1:0] pin = '0;
  logic [NP-1:0] pout, poe;
  logic hold;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coex_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_three_wire_i(tw),
    .cfg_wl_wins_i(wins), .cfg_ant_en_i(ant_en), .cfg_ant_val_i(ant_val),
    .cfg_pad_fn_i(cfg), .wl_active_i(wl_act_in), .pad_in_i(pin),
    .pad_out_o(pout), .pad_oe_o(poe), .wl_holdoff_o(hold)
  );

  function automatic logic [NP*3-1:0] mk(int rp, int pp, int wp, int ap);
    logic [NP*3-1:0] v = '0;
    if (rp >= 0) v[rp*3 +: 3] = 3'd1;
    if (pp >= 0) v[pp*3 +: 3] = 3'd2;
    if (wp >= 0) v[wp*3 +: 3] = 3'd3;
    if (ap >= 0) v[ap*3 +: 3] = 3'd4;
    return v;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cfg = mk(0, 1, 2, -1);
    @(negedge clk);
    chk("R1 act pad", {7'd0, pout[2]}, 8'd0);
    chk("R1 holdoff", {7'd0, hold}, 8'd0);
    rst_n = 1'b1;
    step(2);
    chk("R1 act pad after release", {7'd0, pout[2]}, 8'd0);
    chk("R10 oe act pad only", {1'b0, poe}, 8'h04);

    // R2 latency: grant path, WLAN idle
    pin[0] = 1'b1;
    step(2);
    chk("R2 not yet at edge 2", {7'd0, hold}, 8'd0);
    step(1);
    chk("R2 taken at edge 3", {7'd0, hold}, 8'd1);
    pin[0] = 1'b0;
    step(4);
    chk("R7 holdoff clears", {7'd0, hold}, 8'd0);

    // R3 R4 R5 R7 sweep
    for (int m = 0; m < 16; m++) begin
      logic a, p, w, t, d;
      a = m[0]; p = m[1]; w = m[2]; t = m[3];
      tw = t; wins = w;
      pin = '0; wl_act_in = 1'b0;
      step(4);
      wl_act_in = a;
      step(2);
      pin[1] = p; pin[0] = 1'b1;
      step(4);
      d = a & (~(t & p) | w);
      chk(t ? "R3 R5 three-wire deny" : "R3 R5 two-wire deny", {7'd0, pout[2]}, {7'd0, d});
      chk("R4 holdoff on grant", {7'd0, hold}, {7'd0, ~d});
      if (!d) begin
        wl_act_in = ~a;
        step(3);
        chk("R7 stable in slot", {7'd0, pout[2]}, 8'd0);
        pin[0] = 1'b0;
        step(4);
        chk("R7 holdoff drops", {7'd0, hold}, 8'd0);
      end
    end

    // R6: activity change with no request updates the line
    pin = '0; tw = 1'b0; wins = 1'b0; wl_act_in = 1'b0;
    step(4);
    wl_act_in = 1'b1;
    step(1);
    chk("R6 activity change no request", {7'd0, pout[2]}, 8'd1);
    wl_act_in = 1'b0;
    step(1);
    chk("R6 activity drop", {7'd0, pout[2]}, 8'd0);
    // R6: config change without event has no effect
    tw = 1'b1; wins = 1'b1; wl_act_in = 1'b1;
    pin[1] = 1'b1; pin[0] = 1'b1;
    step(4);
    chk("R6 deny when wlan wins", {7'd0, pout[2]}, 8'd1);
    wins = 1'b0;
    step(3);
    chk("R6 cfg change ignored", {7'd0, pout[2]}, 8'd1);
    chk("R6 no holdoff", {7'd0, hold}, 8'd0);

    // R8 disabled
    pin = '0; wl_act_in = 1'b0; tw = 1'b0;
    step(4);
    en = 1'b0;
    wl_act_in = 1'b1;
    pin[0] = 1'b1;
    step(4);
    chk("R8 act low when disabled", {7'd0, pout[2]}, 8'd0);
    chk("R8 oe kept when disabled", {1'b0, poe}, 8'h04);
    pin[0] = 1'b0; wl_act_in = 1'b0;
    step(4);
    pin[0] = 1'b1;
    step(4);
    chk("R8 no holdoff when disabled", {7'd0, hold}, 8'd0);
    pin = '0;
    en = 1'b1;
    step(4);

    // R9 mapping sweep over request pad
    tw = 1'b1; wins = 1'b0;
    for (int rp = 0; rp < NP; rp++) begin
      int wp, pp;
      wp = (rp + 3) % NP; pp = (rp + 1) % NP;
      cfg = mk(rp, pp, wp, -1);
      pin = '0; wl_act_in = 1'b0;
      step(4);
      wl_act_in = 1'b1;
      step(2);
      pin[rp] = 1'b1;
      step(4);
      chk("R9 mapped request denies", {7'd0, pout[wp]}, 8'd1);
      chk("R10 oe at mapped act pad", {1'b0, poe}, 8'(1 << wp));
      chk("R10 only act pad driven", {1'b0, pout}, 8'(1 << wp));
    end

    // R9 duplicate codes: lowest pad wins
    cfg = mk(1, -1, 3, -1);
    cfg[5*3 +: 3] = 3'd1;
    pin = '0; wl_act_in = 1'b0; tw = 1'b0;
    step(4);
    pin[5] = 1'b1;
    step(4);
    chk("R9 higher duplicate ignored", {7'd0, hold}, 8'd0);
    pin[1] = 1'b1;
    step(4);
    chk("R9 lowest duplicate used", {7'd0, hold}, 8'd1);
    pin = '0;
    step(4);
    // R9 unassigned request reads 0
    cfg = mk(-1, -1, 3, -1);
    pin = '1;
    step(4);
    chk("R9 unassigned request", {7'd0, hold}, 8'd0);
    pin = '0;
    step(4);

    // R10 antenna pad
    cfg = mk(0, -1, 3, 6);
    ant_en = 1'b1; ant_val = 1'b1;
    step(1);
    chk("R10 ant value", {7'd0, pout[6]}, 8'd1);
    chk("R10 ant oe on", {1'b0, poe}, 8'h48);
    ant_en = 1'b0;
    step(1);
    chk("R10 ant oe off", {1'b0, poe}, 8'h08);

    finish_run();
  end
endmodule